// File: doc/BRIEF.md
# T1 Receive Alarm Detector

This block watches a recovered T1 receive bit stream and keeps three alarm flags: loss of signal (`los`), the alarm indication signal or blue alarm (`ais`), and the remote or yellow alarm (`rai`). Every alarm has its own set rule and its own, different clear rule. The flags are what the transmit side and the host alarm logic read.

An external framer supplies the serial data with a bit-clock enable. It also supplies the framing-position strobes: one for the second bit of each channel, one for each framing bit together with the frame number, and one for each received facility data link (FDL) byte. It also drives a loss-of-frame indication. A two-bit format select picks how the remote alarm is recognised. The three choices are superframe with channel bit 2 forced to zero, superframe with the twelfth framing bit, and extended superframe with a repeating pattern on the data link.

Three small state machines hold the flags. The loss-of-signal monitor has three states. In `LOS_IDLE`, zeros are counted and any one restarts the count. The run limit moves it to `LOS_DECLARED`. In `LOS_DECLARED`, the first one received moves it to `LOS_RECOVER`. In `LOS_RECOVER`, enough ones go back to `LOS_IDLE`, and a window that ends without them goes back to `LOS_DECLARED`. The blue-alarm monitor has two states, `AIS_OFF` and `AIS_ON`. It goes from `AIS_OFF` to `AIS_ON` at the end of a quiet window while framing is lost. It goes from `AIS_ON` to `AIS_OFF` at the end of a noisy window, or at once when framing returns. The remote-alarm monitor has the states `RAI_OFF` and `RAI_ON`. The active format decides when it moves between them. A change of format forces it to `RAI_OFF`.

Top module: `t1_rx_alarm_det`

## Requirements
- R1: `los` rises on the clock edge that samples the LOS_ZEROS-th (default 192) consecutive zero taken with `rx_bit_en` high. A one taken with `rx_bit_en` high restarts the run. Cycles with `rx_bit_en` low neither count nor break the run.
- R2: Once `los` is high, the first received one opens a window of LOS_WIN (default 112) enabled bits. `los` falls on the edge that samples the LOS_ONES-th (default 14) one inside that window. If the window ends short of that, `los` stays high and the next received one opens a fresh window.
- R3: Enabled bits are grouped into back-to-back windows of AIS_WIN (default 4632, 3 ms at 1.544 Mb/s), counted from reset. At the end of a window that held AIS_MAX_ZEROS (default 4) or fewer zeros, `ais` rises, but only if `lof` is high.
- R4: At the end of a window that held AIS_MAX_ZEROS+1 or more zeros, `ais` falls. Between window ends, `ais` does not change, except through R5.
- R5: While `lof` is low, `ais` is forced low on the next edge and cannot rise, so a framed all-ones signal never raises it.
- R6: With `fmt_sel`=0 (bit-2 mode), `ch_bit2_stb` pulses are grouped into blocks of B2_CHANS (default 256), and `rx_bit` is sampled on each pulse. At the end of each block, `rai` is set if B2_SET (default 254) or more of the samples were zero, and cleared otherwise.
- R7: With `fmt_sel`=1 (twelfth F-bit mode), `rx_bit` is sampled on each `fbit_stb` where `frame_num` equals FBIT_FRAME (default 12). Strobes in any other frame are ignored. Two consecutive sampled ones set `rai`, and two consecutive sampled zeros clear it.
- R8: With `fmt_sel`=2 (ESF mode), FDL bytes are paired in arrival order, starting with the first byte after reset or after entering the mode. A pair matches when it is 8'h00 followed by 8'hFF. Once FDL_HIST (default 16) pairs have been seen: if all of the last 16 pairs match, `rai` is set; if FDL_CLR (default 14) or fewer of them match, `rai` is cleared; if exactly 15 match, `rai` keeps its value.
- R9: A change of `fmt_sel` clears `rai` and every remote-alarm counter on the next edge. `fmt_sel`=3 keeps `rai` low.
- R10: A synchronous active-high `rst` clears `los`, `ais`, `rai` and every counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Received data bit; also the value sampled by the framing strobes |
| rx_bit_en | input | 1 | One pulse per received bit, for the LOS and AIS counting |
| ch_bit2_stb | input | 1 | `rx_bit` holds bit 2 of a channel |
| fbit_stb | input | 1 | `rx_bit` holds a framing bit |
| frame_num | input | FRAME_W (4) | Frame number within the superframe, 1 to 12, valid with `fbit_stb` |
| fdl_stb | input | 1 | `fdl_byte` holds a new data link byte |
| fdl_byte | input | 8 | Received FDL byte |
| lof | input | 1 | Loss of frame, from the framer |
| fmt_sel | input | 2 | 0 bit-2, 1 twelfth F-bit, 2 ESF, 3 remote alarm disabled |
| los | output | 1 | Loss-of-signal flag |
| ais | output | 1 | Blue-alarm flag |
| rai | output | 1 | Yellow-alarm flag |

## Verification
The bench keeps the loss-of-signal limits at their defaults, since 192 and 112 bits are cheap to send. It shrinks the blue-alarm window to 40 bits and the bit-2 block to 14 zeros out of 16 strobes. With these values the bench can check the window alignment, the exact boundary of 4 zeros against 5 zeros, and several back-to-back set and clear decisions within a few thousand cycles. The bit-2 block keeps the same two-sample margin as the full-size rule, so the set and clear decisions still sit on the same boundary.

// File: rtl/t1_alarm_pkg.sv
package t1_alarm_pkg;

    typedef enum logic [1:0] {
        FMT_D4_BIT2 = 2'd0,
        FMT_D4_FBIT = 2'd1,
        FMT_ESF     = 2'd2,
        FMT_NONE    = 2'd3
    } frm_mode_e;

    typedef enum logic [1:0] {
        LOS_IDLE,
        LOS_DECLARED,
        LOS_RECOVER
    } los_state_e;

    typedef enum logic {
        AIS_OFF,
        AIS_ON
    } ais_state_e;

    typedef enum logic {
        RAI_OFF,
        RAI_ON
    } rai_state_e;

endpackage

// File: rtl/t1_los_mon.sv
module t1_los_mon
    import t1_alarm_pkg::*;
#(
    parameter int ZERO_RUN = 192,
    parameter int WIN      = 112,
    parameter int ONES     = 14
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic bit_val,
    output logic los
);
    localparam int RW = $clog2(ZERO_RUN + 1);
    localparam int WW = $clog2(WIN + 1);
    localparam int OW = $clog2(ONES + 1);

    los_state_e      st_q, st_n;
    logic [RW-1:0]   run_q, run_n;
    logic [WW-1:0]   win_q, win_n;
    logic [OW-1:0]   ones_q, ones_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= LOS_IDLE;
            run_q  <= '0;
            win_q  <= '0;
            ones_q <= '0;
        end else begin
            st_q   <= st_n;
            run_q  <= run_n;
            win_q  <= win_n;
            ones_q <= ones_n;
        end
    end

    always_comb begin
        st_n   = st_q;
        run_n  = run_q;
        win_n  = win_q;
        ones_n = ones_q;
        unique case (st_q)
            LOS_IDLE: begin
                if (bit_en) begin
                    if (bit_val) begin
                        run_n = '0;
                    end else if (run_q == RW'(ZERO_RUN - 1)) begin
                        st_n  = LOS_DECLARED;
                        run_n = '0;
                    end else begin
                        run_n = run_q + RW'(1);
                    end
                end
            end
            LOS_DECLARED: begin
                // recovery window opens on the first one
                if (bit_en && bit_val) begin
                    st_n   = LOS_RECOVER;
                    win_n  = WW'(1);
                    ones_n = OW'(1);
                end
            end
            LOS_RECOVER: begin
                if (bit_en) begin
                    win_n  = win_q + WW'(1);
                    ones_n = ones_q + OW'(bit_val);
                    if (ones_n == OW'(ONES)) begin
                        st_n  = LOS_IDLE;
                        run_n = '0;
                    end else if (win_n == WW'(WIN)) begin
                        st_n = LOS_DECLARED;
                    end
                end
            end
            default: st_n = LOS_IDLE;
        endcase
    end

    always_comb begin
        los = (st_q != LOS_IDLE);
    end

endmodule

// File: rtl/t1_ais_mon.sv
module t1_ais_mon
    import t1_alarm_pkg::*;
#(
    parameter int WIN       = 4632,
    parameter int MAX_ZEROS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic bit_val,
    input  logic lof,
    output logic ais
);
    localparam int CW = $clog2(WIN);
    localparam int ZW = $clog2(MAX_ZEROS + 2);
    localparam logic [ZW-1:0] ZSAT = ZW'(MAX_ZEROS + 1);

    ais_state_e    st_q, st_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic [ZW-1:0] zc_q, zc_n, zsum;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= AIS_OFF;
            cnt_q <= '0;
            zc_q  <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
            zc_q  <= zc_n;
        end
    end

    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        zc_n  = zc_q;
        zsum  = (bit_val || zc_q == ZSAT) ? zc_q : zc_q + ZW'(1);
        if (bit_en) begin
            if (cnt_q == CW'(WIN - 1)) begin
                cnt_n = '0;
                zc_n  = '0;
                unique case (st_q)
                    AIS_OFF: if (lof && zsum <= ZW'(MAX_ZEROS)) st_n = AIS_ON;
                    AIS_ON:  if (zsum > ZW'(MAX_ZEROS))         st_n = AIS_OFF;
                    default: st_n = AIS_OFF;
                endcase
            end else begin
                cnt_n = cnt_q + CW'(1);
                zc_n  = zsum;
            end
        end
        if (!lof) begin
            st_n = AIS_OFF;
        end
    end

    always_comb begin
        ais = (st_q == AIS_ON);
    end

endmodule

// File: rtl/t1_rai_mon.sv
module t1_rai_mon
    import t1_alarm_pkg::*;
#(
    parameter int CHANS      = 256,
    parameter int B2_SET     = 254,
    parameter int FRAME_W    = 4,
    parameter int FBIT_FRAME = 12,
    parameter int HIST       = 16,
    parameter int HIST_CLR   = 14
) (
    input  logic               clk,
    input  logic               rst,
    input  frm_mode_e          mode,
    input  logic               bit_val,
    input  logic               b2_stb,
    input  logic               fb_stb,
    input  logic [FRAME_W-1:0] frame_num,
    input  logic               fdl_stb,
    input  logic [7:0]         fdl_byte,
    output logic               rai
);
    localparam int CW = $clog2(CHANS);
    localparam int ZW = $clog2(CHANS + 1);
    localparam int HW = $clog2(HIST + 1);

    rai_state_e      st_q, st_n;
    frm_mode_e       mode_q;
    logic [CW-1:0]   ch_q, ch_n;
    logic [ZW-1:0]   bz_q, bz_n, bz_sum;
    logic            fp_q, fp_n, fv_q, fv_n;
    logic            ph_q, ph_n;
    logic [7:0]      pb_q, pb_n;
    logic [HIST-1:0] hist_q, hist_n;
    logic [HW-1:0]   fill_q, fill_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= RAI_OFF;
            mode_q <= mode;
            ch_q   <= '0;
            bz_q   <= '0;
            fp_q   <= 1'b0;
            fv_q   <= 1'b0;
            ph_q   <= 1'b0;
            pb_q   <= '0;
            hist_q <= '0;
            fill_q <= '0;
        end else begin
            st_q   <= st_n;
            mode_q <= mode;
            ch_q   <= ch_n;
            bz_q   <= bz_n;
            fp_q   <= fp_n;
            fv_q   <= fv_n;
            ph_q   <= ph_n;
            pb_q   <= pb_n;
            hist_q <= hist_n;
            fill_q <= fill_n;
        end
    end

    always_comb begin
        st_n   = st_q;
        ch_n   = ch_q;
        bz_n   = bz_q;
        fp_n   = fp_q;
        fv_n   = fv_q;
        ph_n   = ph_q;
        pb_n   = pb_q;
        hist_n = hist_q;
        fill_n = fill_q;
        bz_sum = bz_q + ZW'(!bit_val);
        if (mode != mode_q) begin
            st_n   = RAI_OFF;
            ch_n   = '0;
            bz_n   = '0;
            fp_n   = 1'b0;
            fv_n   = 1'b0;
            ph_n   = 1'b0;
            pb_n   = '0;
            hist_n = '0;
            fill_n = '0;
        end else begin
            unique case (mode)
                FMT_D4_BIT2: begin
                    if (b2_stb) begin
                        if (ch_q == CW'(CHANS - 1)) begin
                            ch_n = '0;
                            bz_n = '0;
                            st_n = (bz_sum >= ZW'(B2_SET)) ? RAI_ON : RAI_OFF;
                        end else begin
                            ch_n = ch_q + CW'(1);
                            bz_n = bz_sum;
                        end
                    end
                end
                FMT_D4_FBIT: begin
                    if (fb_stb && frame_num == FRAME_W'(FBIT_FRAME)) begin
                        fp_n = bit_val;
                        fv_n = 1'b1;
                        if (fv_q && fp_q && bit_val) begin
                            st_n = RAI_ON;
                        end else if (fv_q && !fp_q && !bit_val) begin
                            st_n = RAI_OFF;
                        end
                    end
                end
                FMT_ESF: begin
                    if (fdl_stb) begin
                        ph_n = !ph_q;
                        pb_n = fdl_byte;
                        if (ph_q) begin
                            hist_n = {hist_q[HIST-2:0],
                                      (pb_q == 8'h00) && (fdl_byte == 8'hFF)};
                            fill_n = (fill_q == HW'(HIST)) ? fill_q : fill_q + HW'(1);
                            if (fill_n == HW'(HIST)) begin
                                if (&hist_n) begin
                                    st_n = RAI_ON;
                                end else if ($countones(hist_n) <= HIST_CLR) begin
                                    st_n = RAI_OFF;
                                end
                            end
                        end
                    end
                end
                FMT_NONE: st_n = RAI_OFF;
                default:  st_n = RAI_OFF;
            endcase
        end
    end

    always_comb begin
        rai = (st_q == RAI_ON);
    end

endmodule

// File: rtl/t1_rx_alarm_det.sv
module t1_rx_alarm_det
    import t1_alarm_pkg::*;
#(
    parameter int LOS_ZEROS     = 192,
    parameter int LOS_WIN       = 112,
    parameter int LOS_ONES      = 14,
    parameter int AIS_WIN       = 4632,
    parameter int AIS_MAX_ZEROS = 4,
    parameter int B2_CHANS      = 256,
    parameter int B2_SET        = 254,
    parameter int FRAME_W       = 4,
    parameter int FBIT_FRAME    = 12,
    parameter int FDL_HIST      = 16,
    parameter int FDL_CLR       = 14
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rx_bit,
    input  logic               rx_bit_en,
    input  logic               ch_bit2_stb,
    input  logic               fbit_stb,
    input  logic [FRAME_W-1:0] frame_num,
    input  logic               fdl_stb,
    input  logic [7:0]         fdl_byte,
    input  logic               lof,
    input  logic [1:0]         fmt_sel,
    output logic               los,
    output logic               ais,
    output logic               rai
);

    t1_los_mon #(
        .ZERO_RUN (LOS_ZEROS),
        .WIN      (LOS_WIN),
        .ONES     (LOS_ONES)
    ) u_los (
        .clk     (clk),
        .rst     (rst),
        .bit_en  (rx_bit_en),
        .bit_val (rx_bit),
        .los     (los)
    );

    t1_ais_mon #(
        .WIN       (AIS_WIN),
        .MAX_ZEROS (AIS_MAX_ZEROS)
    ) u_ais (
        .clk     (clk),
        .rst     (rst),
        .bit_en  (rx_bit_en),
        .bit_val (rx_bit),
        .lof     (lof),
        .ais     (ais)
    );

    t1_rai_mon #(
        .CHANS      (B2_CHANS),
        .B2_SET     (B2_SET),
        .FRAME_W    (FRAME_W),
        .FBIT_FRAME (FBIT_FRAME),
        .HIST       (FDL_HIST),
        .HIST_CLR   (FDL_CLR)
    ) u_rai (
        .clk       (clk),
        .rst       (rst),
        .mode      (frm_mode_e'(fmt_sel)),
        .bit_val   (rx_bit),
        .b2_stb    (ch_bit2_stb),
        .fb_stb    (fbit_stb),
        .frame_num (frame_num),
        .fdl_stb   (fdl_stb),
        .fdl_byte  (fdl_byte),
        .rai       (rai)
    );

endmodule

// File: rtl/t1_rx_alarm_chk.sv
module t1_rx_alarm_chk #(
    parameter int LOS_ZEROS = 192
) (
    input logic       clk,
    input logic       rst,
    input logic       rx_bit,
    input logic       rx_bit_en,
    input logic       ch_bit2_stb,
    input logic       fbit_stb,
    input logic       fdl_stb,
    input logic       lof,
    input logic [1:0] fmt_sel,
    input logic       los,
    input logic       ais,
    input logic       rai
);
    localparam int RW = $clog2(LOS_ZEROS + 1);
    logic [RW-1:0] zrun;

    always_ff @(posedge clk) begin
        if (rst) begin
            zrun <= '0;
        end else if (rx_bit_en) begin
            if (rx_bit) begin
                zrun <= '0;
            end else if (zrun != RW'(LOS_ZEROS)) begin
                zrun <= zrun + RW'(1);
            end
        end
    end

    // R1
    los_set_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_bit_en && !rx_bit && zrun == RW'(LOS_ZEROS - 1) && !los) |=> los);

    // R1
    los_rise_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(los) |-> $past(rx_bit_en && !rx_bit));

    // R2
    los_fall_one_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(los) |-> $past(rx_bit_en && rx_bit));

    // R3
    ais_rise_lof_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ais) |-> $past(lof && rx_bit_en));

    // R5
    ais_lof_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !lof |=> !ais);

    // R9
    rai_mode_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (fmt_sel != $past(fmt_sel)) |=> !rai);

    // R6
    rai_rise_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rai) |-> $past(ch_bit2_stb || fbit_stb || fdl_stb));

endmodule

bind t1_rx_alarm_det t1_rx_alarm_chk #(
    .LOS_ZEROS (LOS_ZEROS)
) u_alarm_chk (
    .clk         (clk),
    .rst         (rst),
    .rx_bit      (rx_bit),
    .rx_bit_en   (rx_bit_en),
    .ch_bit2_stb (ch_bit2_stb),
    .fbit_stb    (fbit_stb),
    .fdl_stb     (fdl_stb),
    .lof         (lof),
    .fmt_sel     (fmt_sel),
    .los         (los),
    .ais         (ais),
    .rai         (rai)
);

// File: tb/test_t1_rx_alarm_det.sv
module test_t1_rx_alarm_det;
    localparam int AIS_WIN  = 40;
    localparam int B2_CHANS = 16;
    localparam int B2_SET   = 14;

    logic       clk = 1'b0;
    logic       rst;
    logic       rx_bit, rx_bit_en, ch_bit2_stb, fbit_stb, fdl_stb, lof;
    logic [3:0] frame_num;
    logic [7:0] fdl_byte;
    logic [1:0] fmt_sel;
    logic       los, ais, rai;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    t1_rx_alarm_det #(
        .AIS_WIN  (AIS_WIN),
        .B2_CHANS (B2_CHANS),
        .B2_SET   (B2_SET)
    ) i_t1_rx_alarm_det (
        .clk(clk), .rst(rst), .rx_bit(rx_bit), .rx_bit_en(rx_bit_en),
        .ch_bit2_stb(ch_bit2_stb), .fbit_stb(fbit_stb), .frame_num(frame_num),
        .fdl_stb(fdl_stb), .fdl_byte(fdl_byte), .lof(lof), .fmt_sel(fmt_sel),
        .los(los), .ais(ais), .rai(rai)
    );

    // stream segments: value, lof, check ais, expected los, expected ais, length
    typedef struct packed {
        logic        val;
        logic        lof;
        logic        chk_ais;
        logic        e_los;
        logic        e_ais;
        logic [15:0] len;
    } seg_t;

    localparam seg_t SEGS [17] = '{
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 16'd40},   // quiet window, R3
        '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'd200},  // R1 set, R4 clear
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 16'd40},   // R2 clear
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'd40},   // R5 framed ones
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 16'd40},
        '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'd200},
        '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 16'd13},   // R2 13 ones
        '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'd99},   // R2 window expires
        '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 16'd13},   // fresh window
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'd1},    // 14th one
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 16'd34},
        '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 16'd4},
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 16'd36},   // 4 zeros keep AIS
        '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 16'd5},    // mid window: no change
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'd35},   // 5 zeros clear R4
        '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'd4},
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 16'd36}    // 4 zeros set R3
    };

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic clr_in();
        rx_bit_en   = 1'b0;
        ch_bit2_stb = 1'b0;
        fbit_stb    = 1'b0;
        fdl_stb     = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
        clr_in();
    endtask

    task automatic send_bit(input logic v);
        @(negedge clk);
        clr_in();
        rx_bit    = v;
        rx_bit_en = 1'b1;
    endtask

    task automatic send_b2(input logic v);
        @(negedge clk);
        clr_in();
        rx_bit      = v;
        ch_bit2_stb = 1'b1;
    endtask

    task automatic send_fb(input logic [3:0] fn, input logic v);
        @(negedge clk);
        clr_in();
        rx_bit    = v;
        frame_num = fn;
        fbit_stb  = 1'b1;
    endtask

    task automatic send_fdl(input logic [7:0] b);
        @(negedge clk);
        clr_in();
        fdl_byte = b;
        fdl_stb  = 1'b1;
    endtask

    task automatic send_pair(input logic [7:0] a, input logic [7:0] b);
        send_fdl(a);
        send_fdl(b);
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        clr_in();
        fmt_sel = m;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        rst = 1'b1; rx_bit = 1'b0; lof = 1'b1; fmt_sel = 2'd0;
        frame_num = '0; fdl_byte = '0;
        clr_in();
        repeat (3) @(negedge clk);
        check("R10 reset los", los, 1'b0);
        check("R10 reset ais", ais, 1'b0);
        check("R10 reset rai", rai, 1'b0);
        rst = 1'b0;

        // serial stream table: R1 R2 R3 R4 R5
        for (int i = 0; i < 17; i++) begin
            lof = SEGS[i].lof;
            for (int k = 0; k < int'(SEGS[i].len); k++) begin
                send_bit(SEGS[i].val);
            end
            settle();
            check($sformatf("R1 R2 los seg %0d", i), los, SEGS[i].e_los);
            if (SEGS[i].chk_ais) begin
                check($sformatf("R3 R4 R5 ais seg %0d", i), ais, SEGS[i].e_ais);
            end
        end

        // R6 bit-2 mode blocks of 16
        for (int k = 0; k < 16; k++) send_b2(k >= 14);
        settle();
        check("R6 14 zeros of 16 sets", rai, 1'b1);
        for (int k = 0; k < 16; k++) send_b2(k >= 13);
        settle();
        check("R6 13 zeros of 16 clears", rai, 1'b0);
        for (int k = 0; k < 15; k++) send_b2(k < 2);
        settle();
        check("R6 no decision mid block", rai, 1'b0);
        send_b2(1'b0);
        settle();
        check("R6 set at block end", rai, 1'b1);

        // R9 mode change clears
        set_mode(2'd1);
        settle();
        check("R9 mode change clears rai", rai, 1'b0);

        // R7 twelfth F-bit
        send_fb(4'd12, 1'b1);
        send_fb(4'd5, 1'b0);
        send_fb(4'd12, 1'b1);
        settle();
        check("R7 two ones set, frame 5 ignored", rai, 1'b1);
        send_fb(4'd12, 1'b0);
        send_fb(4'd12, 1'b1);
        send_fb(4'd12, 1'b0);
        settle();
        check("R7 alternating holds", rai, 1'b1);
        send_fb(4'd3, 1'b1);
        send_fb(4'd12, 1'b0);
        settle();
        check("R7 two zeros clear", rai, 1'b0);

        // R8 ESF pattern
        set_mode(2'd2);
        for (int k = 0; k < 15; k++) send_pair(8'h00, 8'hFF);
        settle();
        check("R8 15 pairs not enough", rai, 1'b0);
        send_pair(8'h00, 8'hFF);
        settle();
        check("R8 16 pairs set", rai, 1'b1);
        send_pair(8'h00, 8'h0F);
        settle();
        check("R8 15 of 16 holds", rai, 1'b1);
        send_pair(8'hFF, 8'h00);
        settle();
        check("R8 14 of 16 clears", rai, 1'b0);
        for (int k = 0; k < 16; k++) send_pair(8'h00, 8'hFF);
        settle();
        check("R8 set again", rai, 1'b1);

        // R9 disabled format
        set_mode(2'd3);
        settle();
        check("R9 mode 3 clears", rai, 1'b0);
        for (int k = 0; k < 16; k++) send_pair(8'h00, 8'hFF);
        for (int k = 0; k < 16; k++) send_b2(1'b0);
        settle();
        check("R9 mode 3 stays low", rai, 1'b0);

        // R10 reset from active alarms
        set_mode(2'd1);
        for (int k = 0; k < 200; k++) send_bit(1'b0);
        send_fb(4'd12, 1'b1);
        send_fb(4'd12, 1'b1);
        settle();
        check("R10 pre los", los, 1'b1);
        check("R10 pre rai", rai, 1'b1);
        rst = 1'b1;
        settle();
        rst = 1'b0;
        check("R10 los cleared", los, 1'b0);
        check("R10 rai cleared", rai, 1'b0);
        check("R10 ais cleared", ais, 1'b0);

        finish_run();
    end

endmodule